// File: doc/BRIEF.md
# Universal Shift Register with Shared Parallel Pins

This block is a parameterized storage register (eight bits by default) that, on each rising clock edge, either keeps its contents, shifts toward the high end, shifts toward the low end, or captures a parallel word. A single group of parallel pins serves both directions. In parallel-capture mode the pins carry data in. Otherwise they can present the register contents, provided both active-low output enables are low. Each shared pin is modelled as three signals: a pin input, a pin output and a common drive enable. A pad ring or an external bus model resolves them into a real bidirectional pin.

An active-low clear input is sampled on the clock edge and takes priority over the mode select. A dedicated serial input feeds each shift direction. The two end bits are also brought out on serial outputs that are always driven, whatever the output enables do. Two or more instances can therefore be chained into a longer register. To do this, wire the upper end bit of the lower instance into the low-end serial input of the upper instance, and wire the lower end bit of the upper instance into the high-end serial input of the lower instance.

The register's value after power-up is undefined until the first clear.

Top module: `univ_shift_reg`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, every register bit becomes 0 after that edge, whatever the value of `mode_sel`.
- R2: With `rst_n` high and `mode_sel` = 2'b11 (parallel capture), each bit n takes the value of `pin_in[n]` at the edge.
- R3: With `rst_n` high and `mode_sel` = 2'b01 (shift up), bit 0 takes `ser_in_up` and bit n takes the old bit n-1 for n ≥ 1.
- R4: With `rst_n` high and `mode_sel` = 2'b10 (shift down), the top bit takes `ser_in_dn` and bit n takes the old bit n+1 for the other bits.
- R5: With `rst_n` high and `mode_sel` = 2'b00 (hold), the register keeps its value across the edge.
- R6: `pin_oe` is 1 exactly when `oe_a_n` and `oe_b_n` are both 0 and `mode_sel` is not 2'b11. This output is combinational and needs no clock edge. When `pin_oe` is 1, `pin_out` equals the register. When `pin_oe` is 0, `pin_out` is all zeros.
- R7: `ser_out_lo` always equals bit 0 and `ser_out_hi` always equals the top bit, whatever the enables and the mode.
- R8: Clear, shift, capture and hold act on the register in the same way while `pin_oe` is 0.
- R9: Driving `rst_n` low between edges leaves every output unchanged until the next rising edge.
- R10: When two instances are chained through their serial pins, they behave as one register of twice the width in both shift directions.

Top module port list:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low clear, sampled on the clock edge |
| mode_sel | input | 2 | 00 hold, 01 shift up, 10 shift down, 11 parallel capture |
| oe_a_n | input | 1 | Active-low output enable A |
| oe_b_n | input | 1 | Active-low output enable B |
| ser_in_up | input | 1 | Serial bit entering bit 0 when shifting up |
| ser_in_dn | input | 1 | Serial bit entering the top bit when shifting down |
| pin_in | input | WIDTH | Value seen on the shared pins |
| pin_out | output | WIDTH | Value offered to the shared pins |
| pin_oe | output | 1 | Drive enable for the shared pins |
| ser_out_lo | output | 1 | Bit 0, always driven |
| ser_out_hi | output | 1 | Top bit, always driven |

## Verification
A wrong register bit shows at the serial outputs at once if it is an end bit. Otherwise it shows on the shared pins as soon as the pins are driven, which is the first non-capture cycle with both enables low. Each clocked step is therefore followed by a readback in hold mode with the enables low, so any state error is seen one edge after it is made. An error in the enable logic is combinational and is checked in the same cycle as the mode and enable values that cause it. An error in the chaining of two instances reaches the far end bit after at most one register width of shifts.

// File: rtl/usr_pkg.sv
package usr_pkg;

    typedef enum logic [1:0] {
        MODE_HOLD = 2'b00,
        MODE_UP   = 2'b01,
        MODE_DN   = 2'b10,
        MODE_LOAD = 2'b11
    } usr_mode_e;

endpackage

// File: rtl/usr_next_state.sv
module usr_next_state #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] cur_bits,
    input  logic [1:0]       mode_sel,
    input  logic             rst_n,
    input  logic             ser_in_up,
    input  logic             ser_in_dn,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] nxt_bits
);
    import usr_pkg::*;

    localparam int TOP = WIDTH - 1;

    usr_mode_e mode;
    logic [WIDTH-1:0] up_val;
    logic [WIDTH-1:0] dn_val;

    assign mode = usr_mode_e'(mode_sel);

    generate
        if (WIDTH == 1) begin : g_single
            assign up_val = ser_in_up;
            assign dn_val = ser_in_dn;
        end else begin : g_multi
            assign up_val = {cur_bits[TOP-1:0], ser_in_up};
            assign dn_val = {ser_in_dn, cur_bits[TOP:1]};
        end
    endgenerate

    always_comb begin
        nxt_bits = cur_bits;
        if (!rst_n) begin
            nxt_bits = '0;
        end else begin
            unique case (mode)
                MODE_HOLD: nxt_bits = cur_bits;
                MODE_UP:   nxt_bits = up_val;
                MODE_DN:   nxt_bits = dn_val;
                MODE_LOAD: nxt_bits = pin_in;
                default:   nxt_bits = cur_bits;
            endcase
        end
    end

endmodule

// File: rtl/usr_pin_drive.sv
module usr_pin_drive #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] reg_bits,
    input  logic [1:0]       mode_sel,
    input  logic             oe_a_n,
    input  logic             oe_b_n,
    output logic [WIDTH-1:0] pin_out,
    output logic             pin_oe
);
    import usr_pkg::*;

    logic enables_on;
    logic capture_sel;
    logic drive;

    assign enables_on  = ~(oe_a_n | oe_b_n);
    assign capture_sel = (usr_mode_e'(mode_sel) == MODE_LOAD);
    assign drive       = enables_on & ~capture_sel;
    assign pin_oe      = drive;

    for (genvar i = 0; i < WIDTH; i++) begin : g_gate
        assign pin_out[i] = reg_bits[i] & drive;
    end

endmodule

// File: rtl/univ_shift_reg.sv
module univ_shift_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_sel,
    input  logic             oe_a_n,
    input  logic             oe_b_n,
    input  logic             ser_in_up,
    input  logic             ser_in_dn,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_out,
    output logic             pin_oe,
    output logic             ser_out_lo,
    output logic             ser_out_hi
);

    localparam int TOP = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] bits;
    } usr_state_t;

    usr_state_t state_d;
    usr_state_t state_q;
    logic [WIDTH-1:0] nxt_bits;

    usr_next_state #(.WIDTH(WIDTH)) u_next (
        .cur_bits  (state_q.bits),
        .mode_sel  (mode_sel),
        .rst_n     (rst_n),
        .ser_in_up (ser_in_up),
        .ser_in_dn (ser_in_dn),
        .pin_in    (pin_in),
        .nxt_bits  (nxt_bits)
    );

    always_comb begin
        state_d      = state_q;
        state_d.bits = nxt_bits;
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    usr_pin_drive #(.WIDTH(WIDTH)) u_drive (
        .reg_bits (state_q.bits),
        .mode_sel (mode_sel),
        .oe_a_n   (oe_a_n),
        .oe_b_n   (oe_b_n),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe)
    );

    assign ser_out_lo = state_q.bits[0];
    assign ser_out_hi = state_q.bits[TOP];

endmodule

// File: rtl/usr_checker.sv
module usr_checker #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mode_sel,
    input logic             oe_a_n,
    input logic             oe_b_n,
    input logic             ser_in_up,
    input logic             ser_in_dn,
    input logic [WIDTH-1:0] pin_in,
    input logic [WIDTH-1:0] pin_out,
    input logic             pin_oe,
    input logic [WIDTH-1:0] reg_bits
);
    localparam int TOP = WIDTH - 1;

    logic seen_rst = 1'b0;

    always_ff @(posedge clk) begin
        if (!rst_n) seen_rst <= 1'b1;
    end

    assert_clear_R1: assert property (@(posedge clk) disable iff (!seen_rst)
        !rst_n |=> (reg_bits == '0));

    assert_capture_R2: assert property (@(posedge clk) disable iff (!seen_rst)
        (rst_n && mode_sel == 2'b11) |=> (reg_bits == $past(pin_in)));

    assert_shift_up_R3: assert property (@(posedge clk) disable iff (!seen_rst)
        (rst_n && mode_sel == 2'b01) |=>
            (reg_bits[0] == $past(ser_in_up)) && (reg_bits[TOP] == $past(reg_bits[TOP-1])));

    assert_shift_dn_R4: assert property (@(posedge clk) disable iff (!seen_rst)
        (rst_n && mode_sel == 2'b10) |=>
            (reg_bits[TOP] == $past(ser_in_dn)) && (reg_bits[0] == $past(reg_bits[1])));

    assert_hold_R5: assert property (@(posedge clk) disable iff (!seen_rst)
        (rst_n && mode_sel == 2'b00) |=> $stable(reg_bits));

    assert_no_drive_in_capture_R6: assert property (@(posedge clk) disable iff (!seen_rst)
        (mode_sel == 2'b11 || oe_a_n || oe_b_n) |-> !pin_oe);

    assert_quiet_pins_R6: assert property (@(posedge clk) disable iff (!seen_rst)
        !pin_oe |-> (pin_out == '0));

    assert_pins_show_reg_R6: assert property (@(posedge clk) disable iff (!seen_rst)
        pin_oe |-> (pin_out == reg_bits));

endmodule

bind univ_shift_reg usr_checker #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_sel  (mode_sel),
    .oe_a_n    (oe_a_n),
    .oe_b_n    (oe_b_n),
    .ser_in_up (ser_in_up),
    .ser_in_dn (ser_in_dn),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .reg_bits  (state_q.bits)
);

// File: tb/univ_shift_reg_tb.sv
module univ_shift_reg_tb;

    localparam int W      = 8;
    localparam int PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   mode_sel = 2'b11;
    logic         oe_a_n = 1'b1;
    logic         oe_b_n = 1'b1;
    logic         sin_up = 1'b0;
    logic         sin_dn = 1'b0;
    logic [W-1:0] pin_lo_in = '0;
    logic [W-1:0] pin_hi_in = '0;

    logic [W-1:0] pin_lo_out, pin_hi_out;
    logic         oe_lo, oe_hi;
    logic         lo_s0, lo_s7, hi_s0, hi_s7;

    logic [2*W-1:0] exp_q = '0;
    int vectors = 0;
    int fails = 0;
    bit finished = 0;

    always #(PERIOD/2) clk = ~clk;

    univ_shift_reg #(.WIDTH(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
        .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
        .ser_in_up(sin_up), .ser_in_dn(hi_s0),
        .pin_in(pin_lo_in), .pin_out(pin_lo_out), .pin_oe(oe_lo),
        .ser_out_lo(lo_s0), .ser_out_hi(lo_s7)
    );

    univ_shift_reg #(.WIDTH(W)) u_dut_hi (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
        .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
        .ser_in_up(lo_s7), .ser_in_dn(sin_dn),
        .pin_in(pin_hi_in), .pin_out(pin_hi_out), .pin_oe(oe_hi),
        .ser_out_lo(hi_s0), .ser_out_hi(hi_s7)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Serial outputs (R7) and, with pins driven, full contents (R6)
    task automatic readback(input string req);
        @(negedge clk);
        rst_n = 1'b1; mode_sel = 2'b00; oe_a_n = 1'b0; oe_b_n = 1'b0;
        #1;
        check({req, "/R6 drive"}, {30'd0, oe_hi, oe_lo}, 32'd3);
        check(req, {16'd0, pin_hi_out, pin_lo_out}, {16'd0, exp_q});
        check({req, "/R7 ends"}, {28'd0, hi_s7, hi_s0, lo_s7, lo_s0},
              {28'd0, exp_q[15], exp_q[8], exp_q[7], exp_q[0]});
    endtask

    task automatic step(input logic rst, input logic [1:0] md, input logic up, input logic dn,
                        input logic [W-1:0] plo, input logic [W-1:0] phi,
                        input logic ea, input logic eb, input string req);
        logic exp_oe;
        @(negedge clk);
        rst_n = rst; mode_sel = md; sin_up = up; sin_dn = dn;
        pin_lo_in = plo; pin_hi_in = phi; oe_a_n = ea; oe_b_n = eb;
        #1;
        exp_oe = !ea && !eb && (md != 2'b11);
        check("R6 pin_oe", {30'd0, oe_hi, oe_lo}, {30'd0, exp_oe, exp_oe});
        if (!exp_oe) check("R6 quiet pins", {16'd0, pin_hi_out, pin_lo_out}, 32'd0);
        @(posedge clk);
        if (!rst)              exp_q = '0;
        else if (md == 2'b11)  exp_q = {phi, plo};
        else if (md == 2'b01)  exp_q = {exp_q[2*W-2:0], up};
        else if (md == 2'b10)  exp_q = {dn, exp_q[2*W-1:1]};
        readback(req);
    endtask

    initial begin
        // R1: clear with capture mode selected
        step(1'b0, 2'b11, 1'b1, 1'b1, 8'hFF, 8'hFF, 1'b0, 1'b0, "R1 clear");
        step(1'b0, 2'b01, 1'b1, 1'b1, 8'hFF, 8'hFF, 1'b0, 1'b0, "R1 clear");

        // R2: exhaustive capture sweep
        for (int p = 0; p < 256; p++)
            step(1'b1, 2'b11, 1'b0, 1'b0, W'(p), W'(~p), p[0], p[1], "R2 capture");

        // R3 / R10: shift up through the chain
        step(1'b1, 2'b11, 1'b0, 1'b0, 8'hA5, 8'h3C, 1'b0, 1'b0, "R2 capture");
        for (int i = 0; i < 40; i++)
            step(1'b1, 2'b01, 1'((i * 5) % 3 == 0), 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, "R3/R10 shift up");

        // R4 / R10: shift down through the chain
        step(1'b1, 2'b11, 1'b0, 1'b0, 8'h81, 8'h6E, 1'b0, 1'b0, "R2 capture");
        for (int i = 0; i < 40; i++)
            step(1'b1, 2'b10, 1'b0, 1'((i * 7) % 4 < 2), 8'h00, 8'h00, 1'b0, 1'b0, "R4/R10 shift down");

        // R5: hold with all enable combinations
        for (int i = 0; i < 8; i++)
            step(1'b1, 2'b00, 1'b1, 1'b1, 8'hFF, 8'hFF, i[0], i[1], "R5 hold");

        // R8: operations with pins undriven
        for (int i = 0; i < 24; i++)
            step(1'b1, 2'(i % 4), 1'(i % 2), 1'(i % 3 == 0), W'(i * 37), W'(i * 91),
                 1'b1, i[0], "R8 undriven");
        step(1'b0, 2'b10, 1'b1, 1'b1, 8'h55, 8'h55, 1'b1, 1'b1, "R8/R1 clear undriven");

        // R9: clear asserted between edges changes nothing until the edge
        step(1'b1, 2'b11, 1'b0, 1'b0, 8'hC3, 8'h5A, 1'b0, 1'b0, "R2 capture");
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R9 no early clear", {16'd0, pin_hi_out, pin_lo_out}, {16'd0, exp_q});
        check("R9 no early clear ends", {30'd0, hi_s7, lo_s0}, {30'd0, exp_q[15], exp_q[0]});
        @(posedge clk);
        exp_q = '0;
        readback("R1 clear after R9");

        // R6: mode and enable sweep, combinational
        for (int m = 0; m < 4; m++)
            for (int e = 0; e < 4; e++)
                step(1'b1, 2'(m), 1'b1, 1'b0, 8'h0F, 8'hF0, e[0], e[1], "R6 sweep");

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(PERIOD * 200000);
        if (!finished) begin
            vectors++;
            fails++;
            $display("FAIL watchdog actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule